// File: doc/BRIEF.md
# Multi-Level Coarse-Coding Address Generator

This block turns one input vector of `N_COMP` signed fixed-point components into one working-memory address for each of `LEVELS` tiling levels. It is the addressing front end of a tile-coded function approximator. Each level lays a grid of fixed-width intervals over the component range, and the grid of level `j` is shifted by `j * OFS_STEP` range units. For each level, the block finds the interval that each component falls in. It then combines those interval indices as digits of a mixed-radix number, least significant component first. Finally it reduces that number modulo the level's hash size. Weight storage, summation and training belong to other blocks.

A component is expressed in range units measured from the lower end of the range: 0 is the lower bound and `RANGE_U` is the upper bound. Interval edges are constants fixed at elaboration and are compared against the input, so no divider is used. The modulo reduction is applied term by term while the digits accumulate, one component per clock, so no register grows past the hash width. A vector enters through a valid/ready handshake. The per-level addresses leave through a second valid/ready handshake and are held until the consumer accepts them.

The controller has three states. `ST_IDLE` waits with `in_ready` high; the transition `IDLE->SCAN` fires on `in_valid && in_ready` and captures the vector. `ST_SCAN` folds in one component per cycle; `SCAN->SCAN` repeats while components remain and `SCAN->HOLD` fires after the last one. `ST_HOLD` presents the addresses with `out_valid` high; `HOLD->HOLD` repeats while `out_ready` is low and `HOLD->IDLE` fires when `out_ready` is high.

Top module: `cmac_addr_gen`

## Requirements
- R1: On each level, a component lying exactly on an interval edge belongs to the interval above that edge, so every interval is closed on its lower end and open on its upper end.
- R2: Level `j` starts its grid at `j*OFS_STEP`. A nonzero shift gives a first interval that is shorter than `FIELD_W`, and level 0 has one interval fewer than the shifted form would give. With the default parameters, level 0 has two intervals split at 600, and levels 1 to 4 have three intervals whose first edges are at 120, 240, 360 and 480.
- R3: The topmost interval of every level includes the upper bound, so a component equal to `RANGE_U` has index M_j-1, where M_j is the interval count of level j.
- R4: A component below 0 is given interval 0, and a component above `RANGE_U` is given interval M_j-1.
- R5: The virtual address of level j is the sum over components i of s_i·M_j^i. Component i occupies bits `[i*IN_W +: IN_W]` of `in_vec`.
- R6: Field j of `out_addr` (bits `[j*16 +: 16]`) equals the virtual address of level j modulo `HASH_SIZES[j*16 +: 16]`, and it is always below that hash size.
- R7: `in_ready` is high only in `ST_IDLE`, and a vector is taken only on a cycle where `in_valid` and `in_ready` are both high.
- R8: `out_valid` rises on the `N_COMP`-th rising clock edge after the edge that accepts a vector.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_addr` does not change. The edge on which `out_ready` is high returns the block to `ST_IDLE`.
- R10: During and right after reset, `in_ready` is 1 and `out_valid` is 0.
- R11: A vector offered with `in_valid` high while the block is busy is not captured, and the addresses then presented are those of the vector accepted earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An input vector is offered |
| in_ready | output | 1 | The block can accept a vector |
| in_vec | input | N_COMP*IN_W | Signed components in range units, component 0 in the low bits |
| out_valid | output | 1 | Per-level addresses are available |
| out_ready | input | 1 | The consumer takes the addresses |
| out_addr | output | LEVELS*16 | Working address per level, level 0 in the low bits |

## Verification
On every cycle, the assertions check the handshake rules: `in_ready` and `out_valid` are never high together, the block is busy right after an accept, and the output is held under backpressure. They also check that every presented address lies below its level's hash size, and they count the cycles from accept to `out_valid` with a counter. Whether the address values are correct can only be shown by the bench scenarios. These compare the outputs against a reference that works out interval indices by division: at edges and one unit below them, at the upper bound, for clamped values, for single-component digit weights, for a vector offered while the block is busy, and over a pseudo-random sweep.

// File: rtl/cmac_addr_pkg.sv
package cmac_addr_pkg;

    localparam int unsigned ADDR_W = 16;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_HOLD = 2'd2
    } scan_state_e;

    // lowest interval edge of a level: the shift itself, or one width up when unshifted
    function automatic int lowest_edge(input int shift, input int width);
        return (shift == 0) ? width : shift;
    endfunction

    // number of interior edges strictly below the upper bound
    function automatic int edge_count(input int range_u, input int width, input int shift);
        int n;
        n = 0;
        for (int b = lowest_edge(shift, width); b < range_u; b += width) begin
            n++;
        end
        return n;
    endfunction

    function automatic int edge_pos(input int shift, input int width, input int k);
        return lowest_edge(shift, width) + k * width;
    endfunction

endpackage

// File: rtl/cmac_interval_quant.sv
module cmac_interval_quant
    import cmac_addr_pkg::*;
#(
    parameter int IN_W    = 12,
    parameter int RANGE_U = 1200,
    parameter int FIELD_W = 600,
    parameter int SHIFT   = 0,
    parameter int CNT_W   = 2
) (
    input  logic signed [IN_W-1:0] comp_val,
    output logic [CNT_W-1:0]       interval_idx
);

    localparam int NUM_EDGES = edge_count(RANGE_U, FIELD_W, SHIFT);
    localparam int SLOTS     = (NUM_EDGES > 0) ? NUM_EDGES : 1;

    logic signed [31:0] val_ext;
    logic [SLOTS-1:0]   at_or_above;

    assign val_ext = {{(32-IN_W){comp_val[IN_W-1]}}, comp_val};

    // thermometer of edges at or below the value; clamping falls out of it
    for (genvar k = 0; k < SLOTS; k++) begin : g_edge
        localparam int signed EDGE = edge_pos(SHIFT, FIELD_W, k);
        if (k < NUM_EDGES) begin : g_live
            assign at_or_above[k] = (val_ext >= EDGE);
        end else begin : g_none
            assign at_or_above[k] = 1'b0;
        end
    end

    always_comb begin
        interval_idx = '0;
        for (int k = 0; k < SLOTS; k++) begin
            interval_idx = interval_idx + CNT_W'(at_or_above[k]);
        end
    end

endmodule

// File: rtl/cmac_level_fold.sv
module cmac_level_fold
    import cmac_addr_pkg::*;
#(
    parameter int LEVEL_CNT = 3,
    parameter int HASH      = 31,
    parameter int CNT_W     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              step,
    input  logic [CNT_W-1:0]  interval_idx,
    output logic [ADDR_W-1:0] work_addr
);

    localparam int PROD_W   = ADDR_W + CNT_W + 1;
    localparam int MOD_ITER = LEVEL_CNT + 1;

    logic [ADDR_W-1:0] acc_q;
    logic [ADDR_W-1:0] weight_q;
    logic [PROD_W-1:0] acc_sum;
    logic [PROD_W-1:0] weight_prod;

    // operands stay below (LEVEL_CNT+1)*HASH, so bounded subtraction reduces them
    function automatic logic [ADDR_W-1:0] reduce(input logic [PROD_W-1:0] v);
        logic [PROD_W-1:0] r;
        r = v;
        for (int i = 0; i < MOD_ITER; i++) begin
            if (r >= PROD_W'(HASH)) begin
                r = r - PROD_W'(HASH);
            end
        end
        return r[ADDR_W-1:0];
    endfunction

    assign acc_sum     = PROD_W'(acc_q) + PROD_W'(interval_idx) * PROD_W'(weight_q);
    assign weight_prod = PROD_W'(weight_q) * PROD_W'(LEVEL_CNT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q    <= '0;
            weight_q <= '0;
        end else if (start) begin
            acc_q    <= '0;
            weight_q <= reduce(PROD_W'(1));
        end else if (step) begin
            acc_q    <= reduce(acc_sum);
            weight_q <= reduce(weight_prod);
        end
    end

    assign work_addr = acc_q;

endmodule

// File: rtl/cmac_scan_ctrl.sv
module cmac_scan_ctrl
    import cmac_addr_pkg::*;
#(
    parameter int N_COMP = 4,
    parameter int IDX_W  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             out_ready,
    output logic             in_ready,
    output logic             out_valid,
    output logic             start,
    output logic             step,
    output logic [IDX_W-1:0] comp_idx
);

    scan_state_e state_q;
    scan_state_e state_d;
    logic        last_comp;

    assign last_comp = (comp_idx == IDX_W'(N_COMP - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (in_valid)  state_d = ST_SCAN;
            ST_SCAN: if (last_comp) state_d = ST_HOLD;
            ST_HOLD: if (out_ready) state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        step      = 1'b0;
        unique case (state_q)
            ST_IDLE: in_ready  = 1'b1;
            ST_SCAN: step      = 1'b1;
            ST_HOLD: out_valid = 1'b1;
            default: ;
        endcase
    end

    assign start = in_ready && in_valid;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            comp_idx <= '0;
        end else if (start) begin
            comp_idx <= '0;
        end else if (step && !last_comp) begin
            comp_idx <= comp_idx + IDX_W'(1);
        end
    end

endmodule

// File: rtl/cmac_addr_gen.sv
module cmac_addr_gen
    import cmac_addr_pkg::*;
#(
    parameter int N_COMP   = 4,
    parameter int LEVELS   = 5,
    parameter int IN_W     = 12,
    parameter int RANGE_U  = 1200,
    parameter int FIELD_W  = 600,
    parameter int OFS_STEP = 120,
    parameter logic [LEVELS*16-1:0] HASH_SIZES = {16'd97, 16'd61, 16'd37, 16'd31, 16'd13}
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [N_COMP*IN_W-1:0]   in_vec,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic [LEVELS*ADDR_W-1:0] out_addr
);

    localparam int IDX_W = (N_COMP > 1) ? $clog2(N_COMP) : 1;
    localparam int MAX_M = RANGE_U / FIELD_W + 2;
    localparam int CNT_W = $clog2(MAX_M + 1);

    logic                   start;
    logic                   step;
    logic [IDX_W-1:0]       comp_idx;
    logic signed [IN_W-1:0] vec_q [N_COMP];
    logic signed [IN_W-1:0] cur_comp;

    cmac_scan_ctrl #(
        .N_COMP (N_COMP),
        .IDX_W  (IDX_W)
    ) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .start     (start),
        .step      (step),
        .comp_idx  (comp_idx)
    );

    for (genvar i = 0; i < N_COMP; i++) begin : g_cap
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vec_q[i] <= '0;
            end else if (start) begin
                vec_q[i] <= in_vec[i*IN_W +: IN_W];
            end
        end
    end

    assign cur_comp = vec_q[comp_idx];

    for (genvar j = 0; j < LEVELS; j++) begin : g_level
        localparam int SHIFT = j * OFS_STEP;
        localparam int CNT   = edge_count(RANGE_U, FIELD_W, SHIFT) + 1;
        localparam int HASH  = int'(HASH_SIZES[j*16 +: 16]);

        logic [CNT_W-1:0] idx;

        cmac_interval_quant #(
            .IN_W    (IN_W),
            .RANGE_U (RANGE_U),
            .FIELD_W (FIELD_W),
            .SHIFT   (SHIFT),
            .CNT_W   (CNT_W)
        ) quant_i (
            .comp_val     (cur_comp),
            .interval_idx (idx)
        );

        cmac_level_fold #(
            .LEVEL_CNT (CNT),
            .HASH      (HASH),
            .CNT_W     (CNT_W)
        ) fold_i (
            .clk          (clk),
            .rst_n        (rst_n),
            .start        (start),
            .step         (step),
            .interval_idx (idx),
            .work_addr    (out_addr[j*ADDR_W +: ADDR_W])
        );
    end

endmodule

// File: rtl/cmac_addr_gen_chk.sv
module cmac_addr_gen_chk #(
    parameter int N_COMP = 4,
    parameter int LEVELS = 5,
    parameter logic [LEVELS*16-1:0] HASH_SIZES = {16'd97, 16'd61, 16'd37, 16'd31, 16'd13}
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic                 in_ready,
    input logic                 out_valid,
    input logic                 out_ready,
    input logic [LEVELS*16-1:0] out_addr
);

    logic [15:0] busy_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_cnt <= '0;
        end else if (in_valid && in_ready) begin
            busy_cnt <= '0;
        end else if (!in_ready && !out_valid) begin
            busy_cnt <= busy_cnt + 16'd1;
        end
    end

    assert_ready_valid_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid));

    assert_busy_after_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> (busy_cnt == 16'(N_COMP)));

    assert_hold_under_backpressure_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_addr)));

    assert_release_on_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |=> (in_ready && !out_valid));

    for (genvar j = 0; j < LEVELS; j++) begin : g_rng
        assert_addr_below_hash_R6: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (out_addr[j*16 +: 16] < HASH_SIZES[j*16 +: 16]));
    end

endmodule

bind cmac_addr_gen cmac_addr_gen_chk #(
    .N_COMP     (N_COMP),
    .LEVELS     (LEVELS),
    .HASH_SIZES (HASH_SIZES)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_addr  (out_addr)
);

// File: tb/cmac_addr_gen_tb_top.sv
`timescale 1ns/1ps
module cmac_addr_gen_tb_top;

    localparam int N  = 4;
    localparam int L  = 5;
    localparam int IW = 12;
    localparam int RU = 1200;
    localparam int FW = 600;
    localparam int OS = 120;
    localparam logic [L*16-1:0] HS = {16'd97, 16'd61, 16'd37, 16'd31, 16'd13};

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic            out_ready = 1'b0;
    logic [N*IW-1:0] in_vec = '0;
    logic            in_ready;
    logic            out_valid;
    logic [L*16-1:0] out_addr;

    int n_chk = 0;
    int n_bad = 0;
    int cur [N];
    int got [L];
    int lat;
    int unsigned lcg = 32'h1234_5678;

    always #2.5 clk = ~clk;

    cmac_addr_gen #(
        .N_COMP (N), .LEVELS (L), .IN_W (IW), .RANGE_U (RU),
        .FIELD_W (FW), .OFS_STEP (OS), .HASH_SIZES (HS)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_ready (in_ready),
        .in_vec (in_vec), .out_valid (out_valid), .out_ready (out_ready),
        .out_addr (out_addr)
    );

    function automatic int ref_cnt(input int j);
        int o;
        o = j * OS;
        if (o == 0) return (RU % FW > 0) ? RU / FW + 1 : RU / FW;
        return ((RU - o) % FW > 0) ? (RU - o) / FW + 2 : (RU - o) / FW + 1;
    endfunction

    function automatic int ref_idx(input int x, input int j);
        int o, s;
        o = j * OS;
        if (x < 0)           s = 0;
        else if (o == 0)     s = x / FW;
        else if (x < o)      s = 0;
        else                 s = 1 + (x - o) / FW;
        if (s > ref_cnt(j) - 1) s = ref_cnt(j) - 1;
        return s;
    endfunction

    function automatic int ref_addr(input int j);
        longint sum, w;
        sum = 0;
        w = 1;
        for (int i = 0; i < N; i++) begin
            sum += longint'(ref_idx(cur[i], j)) * w;
            w *= ref_cnt(j);
        end
        return int'(sum % longint'(HS[j*16 +: 16]));
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_vec(input int a, input int b, input int c, input int d);
        cur[0] = a; cur[1] = b; cur[2] = c; cur[3] = d;
    endtask

    // drive cur, wait for addresses, leave them held
    task automatic send_and_wait(input bit busy_poke);
        int guard;
        guard = 0;
        @(negedge clk);
        while (!in_ready && guard < 100) begin @(negedge clk); guard++; end
        for (int i = 0; i < N; i++) in_vec[i*IW +: IW] = cur[i][IW-1:0];
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        lat = 0;
        if (busy_poke) begin
            for (int i = 0; i < N; i++) in_vec[i*IW +: IW] = 12'd1100;
            in_valid = 1'b1;
            check("R7 in_ready while busy", int'(in_ready), 0);
            @(negedge clk); lat++;
            check("R7 in_ready while busy", int'(in_ready), 0);
            in_valid = 1'b0;
        end
        while (!out_valid && lat < 100) begin @(negedge clk); lat++; end
        for (int j = 0; j < L; j++) got[j] = int'(out_addr[j*16 +: 16]);
    endtask

    task automatic release_out();
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    task automatic compare_all(input string req);
        for (int j = 0; j < L; j++) check(req, got[j], ref_addr(j));
    endtask

    task automatic t_reset();
        check("R10 in_ready in reset", int'(in_ready), 1);
        check("R10 out_valid in reset", int'(out_valid), 0);
        @(negedge clk); rst_n = 1'b1; @(negedge clk);
        check("R10 in_ready after reset", int'(in_ready), 1);
        check("R10 out_valid after reset", int'(out_valid), 0);
    endtask

    task automatic t_edges();
        set_vec(600, 0, 0, 0);  send_and_wait(0);
        check("R1 level0 at edge 600", got[0], 1);
        check("R8 latency", lat, N);
        release_out();
        set_vec(599, 0, 0, 0);  send_and_wait(0);
        check("R1 level0 below edge", got[0], 0);
        release_out();
        set_vec(120, 119, 0, 0); send_and_wait(0);
        check("R2 level1 first edge 120", got[1], 1);
        check("R2 level2 below 240", got[2], 0);
        compare_all("R1 edge vector");
        release_out();
        set_vec(240, 360, 480, 479); send_and_wait(0);
        compare_all("R2 shifted edges");
        release_out();
    endtask

    task automatic t_upper();
        set_vec(RU, RU, RU, RU); send_and_wait(0);
        check("R3 level0 15 mod 13", got[0], 2);
        check("R3 level1 80 mod 31", got[1], 18);
        check("R3 level2 80 mod 37", got[2], 6);
        check("R3 level3 80 mod 61", got[3], 19);
        check("R3 level4 80 mod 97", got[4], 80);
        release_out();
    endtask

    task automatic t_clamp();
        set_vec(-50, 2000, -2048, 2047); send_and_wait(0);
        compare_all("R4 clamp");
        check("R4 level1 clamp", got[1], (2 * 3 + 2 * 27) % 31);
        release_out();
    endtask

    task automatic t_digits();
        set_vec(0, 0, 0, 1000); send_and_wait(0);
        check("R5 level1 top digit", got[1], (2 * 27) % 31);
        check("R5 level0 top digit", got[0], 8);
        release_out();
        set_vec(0, 700, 0, 0); send_and_wait(0);
        check("R5 level3 second digit", got[3], 3);
        compare_all("R6 digit vector");
        release_out();
    endtask

    task automatic t_backpressure();
        int held [L];
        set_vec(300, 900, 50, 1150); send_and_wait(0);
        for (int j = 0; j < L; j++) held[j] = got[j];
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            check("R9 valid held", int'(out_valid), 1);
            for (int j = 0; j < L; j++) check("R9 addr held", int'(out_addr[j*16 +: 16]), held[j]);
        end
        release_out();
        check("R9 back to idle", int'(in_ready), 1);
        check("R9 valid dropped", int'(out_valid), 0);
    endtask

    task automatic t_busy_ignore();
        set_vec(10, 20, 30, 40); send_and_wait(1);
        compare_all("R11 busy input ignored");
        release_out();
    endtask

    task automatic t_sweep();
        for (int v = 0; v < 40; v++) begin
            for (int i = 0; i < N; i++) begin
                lcg = lcg * 32'd1103515245 + 32'd12345;
                cur[i] = int'((lcg >> 8) % 32'd1500) - 150;
            end
            send_and_wait(0);
            compare_all("R6 sweep");
            check("R8 sweep latency", lat, N);
            release_out();
        end
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_edges();
        t_upper();
        t_clamp();
        t_digits();
        t_backpressure();
        t_busy_ignore();
        t_sweep();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule